// File: doc/BRIEF.md
# Grouped Carry Look-Ahead Adder

This block adds two unsigned operands of equal width and an incoming carry, and returns the sum together with a carry output. It has no clock and no state: every output follows from the present inputs alone. It suits a datapath stage where a ripple chain through every bit would be too slow, but a full multi-level look-ahead tree would cost too much area.

Every bit position first forms two terms. The carry-make term is the AND of the two operand bits and does not depend on any incoming carry. The carry-pass term is the OR of the two operand bits, so an incoming carry passes whenever either operand bit is 1. Bits are collected into slices of four. Within a slice, each of the four carries is built directly from those terms and the slice's incoming carry as a flat sum of products. No carry ripples inside a slice. The slices are chained: the carry leaving one slice is the carry entering the next, and the carry leaving the top slice is the block's carry output. The widest product term has five inputs.

The width `N` is a parameter. It defaults to 16 and must be a multiple of four.

Top module: `cla_adder`

## Requirements
- R1: For every input, `{carry_out, sum_out}` equals `a_in + b_in + carry_in` taken as an unsigned value of N+1 bits.
- R2: The carry into bit i+1 equals (a_i AND b_i) OR ((a_i OR b_i) AND c_i). Here c_i is the carry into bit i, c_0 is `carry_in`, and the carry into bit N is `carry_out`.
- R3: Bit i of `sum_out` equals a_i XOR b_i XOR c_i. Here c_i is the carry that the true sum of the operand bits below i, plus `carry_in`, produces into bit i.
- R4: The carry entering bit 4k, for every slice k above the lowest, equals the carry out of bits 0 to 4k-1. `carry_out` equals the carry out of the whole width.
- R5: When a_i and b_i are both 1, the carry into bit i+1 (or `carry_out` for the top bit) is 1, whatever the lower bits and `carry_in` are.
- R6: When a_i and b_i are both 0, the carry into bit i+1 (or `carry_out` for the top bit) is 0, whatever the lower bits and `carry_in` are.
- R7: When `b_in` is the bitwise inverse of `a_in`, `carry_in` travels the whole width:
  - with `carry_in` 0, `sum_out` is all ones and `carry_out` is 0;
  - with `carry_in` 1, `sum_out` is all zeros and `carry_out` is 1.
- R8: Boundary values:
  - all-zero operands with `carry_in` 0 give a zero sum and a zero `carry_out`;
  - all-one operands with `carry_in` 1 give an all-ones sum and a `carry_out` of 1.
- R9: R1 holds at N = 4 for all 512 combinations of the two operands and `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First unsigned operand |
| b_in | input | N | Second unsigned operand |
| carry_in | input | 1 | Incoming carry, weight 1 |
| sum_out | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of bit N-1 |

## Verification
All results are combinational, so each one is due in the same cycle as the stimulus that produces it, with no register on any path. The bench applies every operand set on a falling clock edge. It reads the outputs 5 ns later, while the inputs are held steady and well clear of the next rising edge. A behavioural reference is computed in the bench from integer sums: the full sum, and the carry into each bit taken from the partial sum of the lower bits. The bench compares that reference against the sum bits and the carry output on every vector. It also recovers the carries at the ports as sum bit XOR a bit XOR b bit, and uses them for the carry-make, carry-kill and slice-link checks.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GRP_W = 4;
  typedef logic [GRP_W-1:0] grp_vec_t;
endpackage

// File: rtl/cla_gp_cell.sv
module cla_gp_cell #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] make_c,
  output logic [W-1:0] pass_c,
  output logic [W-1:0] half_s
);
  // One cell per bit: carry-make, carry-pass and the carry-free half sum.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign make_c[i] = a[i] & b[i];
    assign pass_c[i] = a[i] | b[i];
    assign half_s[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/cla_group4.sv
module cla_group4
  import cla_pkg::*;
(
  input  grp_vec_t make_c,
  input  grp_vec_t pass_c,
  input  grp_vec_t half_s,
  input  logic     c_in,
  output grp_vec_t sum,
  output logic     c_out
);
  logic [GRP_W-1:0] c_bit;

  // Each carry is a flat two-level sum of products of make/pass terms
  // and the slice carry-in. Nothing ripples inside the slice.
  assign c_bit[0] = c_in;
  assign c_bit[1] = make_c[0]
                  | (pass_c[0] & c_in);
  assign c_bit[2] = make_c[1]
                  | (pass_c[1] & make_c[0])
                  | (pass_c[1] & pass_c[0] & c_in);
  assign c_bit[3] = make_c[2]
                  | (pass_c[2] & make_c[1])
                  | (pass_c[2] & pass_c[1] & make_c[0])
                  | (pass_c[2] & pass_c[1] & pass_c[0] & c_in);
  assign c_out    = make_c[3]
                  | (pass_c[3] & make_c[2])
                  | (pass_c[3] & pass_c[2] & make_c[1])
                  | (pass_c[3] & pass_c[2] & pass_c[1] & make_c[0])
                  | (pass_c[3] & pass_c[2] & pass_c[1] & pass_c[0] & c_in);

  assign sum = half_s ^ c_bit;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         carry_in,
  output logic [N-1:0] sum_out,
  output logic         carry_out
);
  localparam int GW   = cla_pkg::GRP_W;
  localparam int NGRP = N / GW;

  if ((N % GW) != 0 || N < GW) begin : g_bad_width
    $error("cla_adder: N must be a positive multiple of four");
  end

  logic [N-1:0]  mk;
  logic [N-1:0]  ps;
  logic [N-1:0]  hs;
  logic [NGRP:0] grp_c;

  cla_gp_cell #(.W(N)) u_gp (
    .a      (a_in),
    .b      (b_in),
    .make_c (mk),
    .pass_c (ps),
    .half_s (hs)
  );

  assign grp_c[0] = carry_in;

  for (genvar k = 0; k < NGRP; k++) begin : g_slice
    cla_group4 u_grp (
      .make_c (mk[GW*k +: GW]),
      .pass_c (ps[GW*k +: GW]),
      .half_s (hs[GW*k +: GW]),
      .c_in   (grp_c[k]),
      .sum    (sum_out[GW*k +: GW]),
      .c_out  (grp_c[k+1])
    );
  end

  assign carry_out = grp_c[NGRP];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic           cin,
  input logic [N-1:0]   sum,
  input logic           cout,
  input logic [N/4:0]   grp_c
);
  localparam int NG = N / 4;

  logic [N:0] rc;   // carries rebuilt bit by bit with the recurrence
  logic [N:0] dc;   // carries recovered from the design's ports
  logic       known;

  always_comb begin
    rc[0] = cin;
    for (int i = 0; i < N; i++)
      rc[i+1] = (a[i] & b[i]) | ((a[i] | b[i]) & rc[i]);
  end

  assign dc    = {cout, sum ^ a ^ b};
  assign known = !$isunknown({a, b, cin, sum, cout, grp_c});

  always_comb begin
    if (known) begin
      p_total_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
        else $error("R1 total mismatch");
      p_recur_r2: assert (cout == rc[N])
        else $error("R2 carry out differs from recurrence");
      p_sum_xor_r3: assert (sum == (a ^ b ^ rc[N-1:0]))
        else $error("R3 sum bits differ");
      for (int k = 0; k <= NG; k++) begin
        p_slice_link_r4: assert (grp_c[k] == rc[4*k])
          else $error("R4 slice carry %0d wrong", k);
      end
      for (int i = 0; i < N; i++) begin
        if (a[i] & b[i]) begin
          p_generate_r5: assert (dc[i+1])
            else $error("R5 make not honoured at bit %0d", i);
        end
        if (!a[i] & !b[i]) begin
          p_kill_r6: assert (!dc[i+1])
            else $error("R6 kill not honoured at bit %0d", i);
        end
      end
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.N(N)) u_chk (
  .a     (a_in),
  .b     (b_in),
  .cin   (carry_in),
  .sum   (sum_out),
  .cout  (carry_out),
  .grp_c (grp_c)
);

// File: tb/cla_adder_test.sv
`timescale 1ns/1ps
module cla_adder_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;
  logic [3:0]  a4 = '0, b4 = '0, s4;
  logic        c4 = 1'b0, co4;

  cla_adder #(.N(16)) uut (
    .a_in(a16), .b_in(b16), .carry_in(c16), .sum_out(s16), .carry_out(co16));
  cla_adder #(.N(4)) uut4 (
    .a_in(a4), .b_in(b4), .carry_in(c4), .sum_out(s4), .carry_out(co4));

  task automatic chk(input bit ok, input string req,
                     input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Full reference comparison for one vector of width w
  task automatic check_vec(input int w, input logic [63:0] a, input logic [63:0] b,
                           input logic ci, input logic [63:0] s, input logic co);
    logic [63:0] mask, mi, tot, rci;
    logic [64:0] d;
    bit ok;
    mask = (64'd1 << w) - 64'd1;
    tot  = (a & mask) + (b & mask) + {63'd0, ci};
    chk((s & mask) == (tot & mask) && co == tot[w], "R1 total",
        {co, s}, {1'b0, tot});
    // R3: sum bit versus reference carry from lower partial sum
    ok = 1'b1; rci = '0;
    for (int i = 0; i < w; i++) begin
      mi = (64'd1 << i) - 64'd1;
      rci[i] = (((a & mi) + (b & mi) + {63'd0, ci}) >> i) & 64'd1;
      if (s[i] != (a[i] ^ b[i] ^ rci[i])) ok = 1'b0;
    end
    chk(ok, "R3 sum xor", {1'b0, s}, {1'b0, (a ^ b ^ rci) & mask});
    // carries recovered from ports
    d = '0;
    for (int i = 0; i < w; i++) d[i] = s[i] ^ a[i] ^ b[i];
    d[w] = co;
    ok = (d[0] == ci);
    for (int i = 0; i < w; i++)
      if (d[i+1] != ((a[i] & b[i]) | ((a[i] | b[i]) & d[i]))) ok = 1'b0;
    chk(ok, "R2 recurrence", d, {1'b0, rci});
    // R4: slice boundaries and final carry
    ok = (co == tot[w]);
    for (int k = 1; k < w / 4; k++) if (d[4*k] != rci[4*k]) ok = 1'b0;
    chk(ok, "R4 slice link", d, {tot[w], rci});
    // R5 / R6
    ok = 1'b1;
    for (int i = 0; i < w; i++) if (a[i] & b[i] & !d[i+1]) ok = 1'b0;
    chk(ok, "R5 make", d, {1'b0, (a & b) << 1});
    ok = 1'b1;
    for (int i = 0; i < w; i++) if (!a[i] & !b[i] & d[i+1]) ok = 1'b0;
    chk(ok, "R6 kill", d, {1'b0, (a | b) << 1});
  endtask

  task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic ci);
    @(negedge clk);
    a16 = a; b16 = b; c16 = ci;
    #5;
    check_vec(16, {48'd0, a}, {48'd0, b}, ci, {48'd0, s16}, co16);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8 zero state
    apply16(16'h0000, 16'h0000, 1'b0);
    chk(s16 == 16'h0 && co16 == 1'b0, "R8 all zero", {co16, s16}, 17'h0);
    // R8 all ones with carry-in
    apply16(16'hFFFF, 16'hFFFF, 1'b1);
    chk(s16 == 16'hFFFF && co16 == 1'b1, "R8 all ones", {co16, s16}, 17'h1FFFF);
    apply16(16'hFFFF, 16'hFFFF, 1'b0);
    apply16(16'h0000, 16'h0000, 1'b1);
    // R7 full-width pass
    apply16(16'hA5C3, 16'h5A3C, 1'b0);
    chk(s16 == 16'hFFFF && co16 == 1'b0, "R7 pass cin0", {co16, s16}, 17'h0FFFF);
    apply16(16'hA5C3, 16'h5A3C, 1'b1);
    chk(s16 == 16'h0000 && co16 == 1'b1, "R7 pass cin1", {co16, s16}, 17'h10000);
    apply16(16'hFFFF, 16'h0000, 1'b1);
    chk(s16 == 16'h0000 && co16 == 1'b1, "R7 ones plus cin", {co16, s16}, 17'h10000);
    // slice boundary carries
    apply16(16'h000F, 16'h0001, 1'b0);
    apply16(16'h0FFF, 16'h0000, 1'b1);
    apply16(16'h8000, 16'h8000, 1'b0);
    apply16(16'h7777, 16'h8888, 1'b1);
    // random vectors at N = 16
    for (int r = 0; r < 1500; r++)
      apply16(16'($urandom), 16'($urandom), 1'($urandom));
    // R9 exhaustive at N = 4
    for (int v = 0; v < 512; v++) begin
      @(negedge clk);
      a4 = v[3:0]; b4 = v[7:4]; c4 = v[8];
      #5;
      chk({co4, s4} == ({1'b0, a4} + {1'b0, b4} + {4'd0, c4}), "R9 exhaustive",
          {60'd0, co4, s4}, {60'd0, ({1'b0, a4} + {1'b0, b4} + {4'd0, c4})});
      check_vec(4, {60'd0, a4}, {60'd0, b4}, c4, {60'd0, s4}, co4);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule